// File: doc/BRIEF.md
# Dual-Edge Strobe Watchdog With Startup Window

This block watches a software strobe line and raises a one-cycle expiry pulse when the strobe has held one level for too long. Any qualified change of level, high-going or low-going, restarts the count. The pulse is meant to feed the reset supervisor. While the supervisor holds its reset output active, the watchdog stays cleared.

Each release of that supervisor reset, and each re-enable of the watchdog, starts a long startup window. In this window the first strobe change only has to appear before `START_CYCLES` cycles have elapsed. The first qualified change switches the block to the normal limit of `RUN_CYCLES`. The strobe passes through a two-stage synchronizer and a width filter, so a change only counts once the new level has been steady for `MIN_WIDTH` cycles.

A dedicated enable input takes the place of detecting a floating strobe pin. While it is low, the watchdog never expires.

Top module: `strobe_watchdog`

## Requirements
- R1: While `rst` is high at a clock edge, `expire_o` is low after that edge. The count is cleared and the block is in startup mode.
- R2: A rising or a falling strobe change both restart the count. If the new level is applied before clock edge k and held, and no other change follows, `expire_o` is high only after edge k+RUN_CYCLES+MIN_WIDTH+2 (40+2+2 = 44 with the defaults).
- R3: In startup mode the limit is `START_CYCLES`. If the hold (supervisor reset high or enable low) is released before edge k and no strobe change follows, `expire_o` is high after edge k+START_CYCLES-1, and low after the edges just before and just after.
- R4: The first qualified strobe change after a release switches the block to the normal limit, so later expiries follow the R2 timing and not the R3 timing.
- R5: `expire_o` is high for exactly one cycle. The count then restarts from zero and the mode is kept, so with no strobe activity the pulses repeat every `RUN_CYCLES` cycles in normal mode and every `START_CYCLES` cycles in startup mode.
- R6: While `sup_reset_i` is high, `expire_o` stays low, the count is cleared and startup mode is re-entered. Time spent in this hold does not count toward the next expiry.
- R7: While `wd_enable_i` is low, `expire_o` stays low and strobe changes are ignored. Raising the enable again starts the R3 startup window.
- R8: A strobe level held for fewer than `MIN_WIDTH` cycles is discarded and does not restart the count. A level held for exactly `MIN_WIDTH` cycles counts as a change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| sup_reset_i | input | 1 | Reset-active level from the supervisor; clears and holds the watchdog |
| wd_enable_i | input | 1 | High to arm the watchdog; low keeps it cleared |
| strobe_i | input | 1 | Asynchronous watchdog strobe from software |
| expire_o | output | 1 | One-cycle pulse when the strobe timed out |

## Verification
A strobe change applied before edge k reaches the counter after three register stages plus the filter: two synchronizer flops and `MIN_WIDTH` cycles of qualification. An expiry from that change therefore lands after edge k+RUN_CYCLES+MIN_WIDTH+2. A release of the hold lands its expiry after edge k+START_CYCLES-1. The bench drives and samples only on falling clock edges and counts rising edges from the drive point. It checks the output low one cycle before the due edge, high on it, and low one cycle after. The table-driven part counts the pulses inside each hold interval; its hold lengths were picked so that every pulse lands a known number of cycles from an interval boundary.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic {
        WD_START = 1'b0,
        WD_RUN   = 1'b1
    } wd_mode_e;

    typedef struct packed {
        logic hold;
        logic kick;
    } wd_ctrl_t;

    function automatic int wd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int wd_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wdt_strobe_qual.sv
module wdt_strobe_qual #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_WIDTH   = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic kick_o
);
    import wdt_pkg::*;

    localparam int WW = wd_width(MIN_WIDTH);
    localparam logic [WW-1:0] W_LAST = WW'(MIN_WIDTH - 1);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   level_q;
    logic [WW-1:0]          wcnt_q;
    logic                   sampled;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain_q[0] <= 1'b0;
                else     chain_q[0] <= strobe_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else     chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign sampled = chain_q[SYNC_STAGES-1];

    // width filter: a new level must persist MIN_WIDTH cycles to be accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            wcnt_q  <= '0;
            kick_o  <= 1'b0;
        end else if (sampled != level_q) begin
            if (wcnt_q == W_LAST) begin
                level_q <= sampled;
                wcnt_q  <= '0;
                kick_o  <= 1'b1;
            end else begin
                wcnt_q  <= wcnt_q + 1'b1;
                kick_o  <= 1'b0;
            end
        end else begin
            wcnt_q <= '0;
            kick_o <= 1'b0;
        end
    end

    // R8: the accepted level moves only together with a kick
    a_r8_level_moves_with_kick: assert property (@(posedge clk) disable iff (rst)
        kick_o |-> (level_q != $past(level_q)));
    a_r8_level_still_without_kick: assert property (@(posedge clk) disable iff (rst)
        !kick_o |-> $stable(level_q));

endmodule

// File: rtl/wdt_period_ctr.sv
module wdt_period_ctr #(
    parameter int START_CYCLES = 200,
    parameter int RUN_CYCLES   = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  wdt_pkg::wd_ctrl_t ctrl,
    output logic              expire_o
);
    import wdt_pkg::*;

    localparam int CW = wd_width(wd_max(START_CYCLES, RUN_CYCLES));
    localparam logic [CW-1:0] START_LAST = CW'(START_CYCLES - 1);
    localparam logic [CW-1:0] RUN_LAST   = CW'(RUN_CYCLES - 1);

    wd_mode_e      mode_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;

    always_comb begin
        last_cnt = (mode_q == WD_START) ? START_LAST : RUN_LAST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= WD_START;
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else if (ctrl.hold) begin
            mode_q   <= WD_START;
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else if (ctrl.kick) begin
            mode_q   <= WD_RUN;
            cnt_q    <= '0;
            expire_o <= 1'b0;
        end else if (cnt_q == last_cnt) begin
            cnt_q    <= '0;
            expire_o <= 1'b1;
        end else begin
            cnt_q    <= cnt_q + 1'b1;
            expire_o <= 1'b0;
        end
    end

    // R2, R4: a kick restarts the count and selects the normal limit
    a_r2_kick_restarts: assert property (@(posedge clk) disable iff (rst)
        (ctrl.kick && !ctrl.hold) |=> (cnt_q == '0 && !expire_o && mode_q == WD_RUN));
    // R3, R6: the hold clears and forces startup mode
    a_r3_hold_startup: assert property (@(posedge clk) disable iff (rst)
        ctrl.hold |=> (cnt_q == '0 && !expire_o && mode_q == WD_START));
    // R5: count never passes the active limit
    a_r5_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= last_cnt);
    // R5: after a pulse the count starts again from zero
    a_r5_restart: assert property (@(posedge clk) disable iff (rst)
        expire_o |-> (cnt_q == '0));

endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
    parameter int START_CYCLES = 200,
    parameter int RUN_CYCLES   = 40,
    parameter int MIN_WIDTH    = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_reset_i,
    input  logic wd_enable_i,
    input  logic strobe_i,
    output logic expire_o
);
    import wdt_pkg::*;

    logic     kick;
    wd_ctrl_t ctrl;

    wdt_strobe_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_WIDTH   (MIN_WIDTH)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .strobe_i (strobe_i),
        .kick_o   (kick)
    );

    always_comb begin
        ctrl.hold = sup_reset_i | ~wd_enable_i;
        ctrl.kick = kick & wd_enable_i;
    end

    wdt_period_ctr #(
        .START_CYCLES (START_CYCLES),
        .RUN_CYCLES   (RUN_CYCLES)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .ctrl     (ctrl),
        .expire_o (expire_o)
    );

    // R1: reset leaves the output low
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !expire_o);
    // R5: the expiry is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        expire_o |=> !expire_o);
    // R6: no expiry while the supervisor holds reset
    a_r6_sup_quiet: assert property (@(posedge clk) disable iff (rst)
        sup_reset_i |=> !expire_o);
    // R7: no expiry while disabled
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !wd_enable_i |=> !expire_o);

endmodule

// File: tb/strobe_watchdog_bench.sv
module strobe_watchdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int START_C = 200;
    localparam int RUN_C   = 40;
    localparam int WID     = 2;
    localparam int KICK_DUE  = RUN_C + WID + 2;
    localparam int START_DUE = START_C - 1;

    localparam int NVEC = 7;
    localparam int V_LVL   [NVEC] = '{0, 1, 0, 1, 0, 1, 0};
    localparam int V_HOLD  [NVEC] = '{30, 30, 35, 100, 43, 45, 20};
    localparam int V_PULSE [NVEC] = '{0, 0, 0, 2, 0, 2, 0};

    logic clk = 1'b0;
    logic rst, sup_reset, wd_enable, strobe, expire;
    int checks = 0;
    int errors = 0;

    strobe_watchdog #(
        .START_CYCLES (START_C),
        .RUN_CYCLES   (RUN_C),
        .MIN_WIDTH    (WID),
        .SYNC_STAGES  (2)
    ) u_strobe_watchdog (
        .clk         (clk),
        .rst         (rst),
        .sup_reset_i (sup_reset),
        .wd_enable_i (wd_enable),
        .strobe_i    (strobe),
        .expire_o    (expire)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // count pulses over n cycles (samples after the next n edges)
    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (expire) cnt++;
        end
    endtask

    // input changed before edge k: pulse due after edge k+due only
    task automatic expect_pulse_at(input int due, input string tag);
        repeat (due) @(posedge clk);
        @(negedge clk);
        chk({tag, " before due edge"}, int'(expire), 0);
        step();
        chk({tag, " on due edge"}, int'(expire), 1);
        step();
        chk({tag, " after due edge"}, int'(expire), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; sup_reset = 1'b1; wd_enable = 1'b1; strobe = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R1 output low in reset", int'(expire), 0);
        end
        rst = 1'b0;

        // R6: long supervisor hold gives no expiry
        count_pulses(300, n);
        chk("R6 no pulse while held", n, 0);

        // R3: startup window from release
        sup_reset = 1'b0;
        expect_pulse_at(START_DUE, "R3 startup expiry");
        // R5: repeats in startup mode every START_C cycles
        expect_pulse_at(START_C - 2, "R5 startup repeat");

        // R1: mid-run block reset clears the count
        count_pulses(100, n);
        chk("R1 no pulse before reset", n, 0);
        rst = 1'b1;
        step(); step();
        chk("R1 output low after reset", int'(expire), 0);
        rst = 1'b0;
        expect_pulse_at(START_DUE, "R1 full window after reset");

        // R6: supervisor hold discards elapsed time
        count_pulses(150, n);
        chk("R6 no pulse before hold", n, 0);
        sup_reset = 1'b1;
        step(); step(); step();
        sup_reset = 1'b0;
        expect_pulse_at(START_DUE, "R6 full window after hold");

        // R4: first change in startup switches to the normal limit
        count_pulses(100, n);
        chk("R4 no pulse before first change", n, 0);
        strobe = 1'b1;
        expect_pulse_at(KICK_DUE, "R4 normal limit after first change");

        // table of strobe levels and hold times (R2 R5)
        for (int v = 0; v < NVEC; v++) begin
            strobe = V_LVL[v][0];
            count_pulses(V_HOLD[v], n);
            chk($sformatf("R2 R5 vector %0d pulses", v), n, V_PULSE[v]);
        end

        // R2: exact timing, rising then falling change
        strobe = 1'b1;
        expect_pulse_at(KICK_DUE, "R2 rising change timing");
        strobe = 1'b0;
        expect_pulse_at(KICK_DUE, "R2 falling change timing");

        // R8: one-cycle glitch is discarded
        strobe = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        strobe = 1'b0;
        step();
        strobe = 1'b1;
        expect_pulse_at(KICK_DUE - 11, "R8 short glitch ignored");

        // R8: a level held exactly MIN_WIDTH cycles counts
        strobe = 1'b0;
        step(); step();
        strobe = 1'b1;
        expect_pulse_at(KICK_DUE, "R8 minimum width accepted");

        // R7: disabled, strobe activity ignored, no expiry
        wd_enable = 1'b0;
        n = 0;
        for (int i = 0; i < 300; i++) begin
            if (i % 50 == 0) strobe = ~strobe;
            step();
            if (expire) n++;
        end
        chk("R7 no pulse while disabled", n, 0);
        wd_enable = 1'b1;
        expect_pulse_at(START_DUE, "R7 startup after re-enable");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule